// File: doc/BRIEF.md
# Handheld Cartridge Bridge Register Interface

This block sits between a host controller and a slot for a handheld game cartridge. The host sees a 16-bit address window with a byte-wide synchronous read/write port. The top four address bits pick one of four functions: a bridge on/off control, a bank register, a cartridge power control with status, and a 16 KiB banked data window. Window accesses are forwarded to the cartridge as a 16-bit cartridge address with single-cycle read and write strobes.

Cartridge power is controlled through the block. Switching power on also issues a one-cycle mapper-reset pulse. A two-bit reset-progress counter is visible in the power/status byte. It moves only when the host reads that byte, so host software can poll its way through a cartridge reset handshake. Turning the bridge on from the off state forces the bank to its highest value, clears the counter and removes cartridge power. The cartridge mapper and the storage behind it are outside this block.

Top module: `cart_bridge`

## Requirements
- R1: After reset the bridge is off, the bank is 0, the progress counter is 3, cartridge power and the mapper-reset pulse are low, and host_rdata is 0x00.
- R2: The function is host_addr[15:12]. In function 0x8, writing 0xFE turns the bridge off, writing 0x84 turns it on, and any other byte changes nothing. Reading function 0x8 gives 0x84 when the bridge is on and 0x00 when it is off.
- R3: Writing 0x84 to function 0x8 while the bridge is off sets the bank to 3, clears the counter to 0 and drops cartridge power. The same write while the bridge is already on leaves bank, counter and power unchanged.
- R4: A write to function 0xA loads the bank from the data byte, and a byte above 3 loads 0. The write has no effect while the bridge is off. The bank appears as cart_addr[15:14] during window accesses.
- R5: A write to function 0xB with data bit 0 set raises cartridge power if a cartridge is present. If power was off, the same write sets the counter to 3 and mapper_rst is high for exactly the one cycle after the write. A write with bit 0 clear drops power. Writes to 0xB are accepted whether or not the bridge is on.
- R6: A read of function 0xB returns bit 0 = cartridge power, bits [3:2] = counter and bit 7 = bridge on. All other bits are 0. The counter value returned is the one held before the read.
- R7: After each read of function 0xB the counter steps 3→2 if power is on, 2→1 if power is off, and 1→0 if power is off. In all other cases it holds.
- R8: An access to 0xC000–0xFFFF with the bridge on and a cartridge present drives cart_addr = bank×0x4000 + host_addr[13:0]. It asserts cart_rd or cart_wr in that same cycle only, and passes host_wdata to cart_wdata. A read returns cart_rdata.
- R9: A window access with the bridge off, or with no cartridge present, raises no strobe, and a read of it returns 0x00.
- R10: Reads of functions other than 0x8, 0xB and 0xC–0xF return 0x00. Writes to functions other than 0x8, 0xA, 0xB and 0xC–0xF change nothing.
- R11: Read data appears on host_rdata in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, one per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| cart_present | input | 1 | Cartridge inserted |
| cart_rdata | input | 8 | Byte returned by the cartridge |
| cart_addr | output | 16 | Banked cartridge address |
| cart_wdata | output | 8 | Byte sent to the cartridge |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_pwr | output | 1 | Cartridge power enable |
| mapper_rst | output | 1 | One-cycle mapper reset pulse |

## Verification
A directed sequence walks the reset handshake: enabling from off, powering on, then polling the status byte through every counter step. Both power states are used, so a counter that steps regardless of power is caught. The bank register is tested with 0..3, with values above 3 and with writes while the bridge is off. Each case is read back through the window address, which separates clamping errors from gating errors. Seeded random traffic across all functions follows, with cartridge presence and enable toggling. This exposes strobes or status bits that ignore enable or presence, and mapper pulses that fire on a repeat power-on.

// File: rtl/cb_pkg.sv
// Shared constants and types for the cartridge bridge.
// Assumes a byte-wide host port and a four-bit function field at the top of the address.
package cb_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int FUNC_W = 4;
    localparam int CNT_W  = 2;

    localparam logic [DATA_W-1:0] CODE_ON     = 8'h84;
    localparam logic [DATA_W-1:0] CODE_OFF    = 8'hFE;
    localparam logic [DATA_W-1:0] STATUS_ON   = 8'h84;
    localparam logic [CNT_W-1:0]  CNT_FULL    = 2'd3;

    typedef enum logic [2:0] {
        FN_NONE = 3'd0,
        FN_CTRL = 3'd1,
        FN_BANK = 3'd2,
        FN_PWR  = 3'd3,
        FN_WIN  = 3'd4
    } func_e;
endpackage

// File: rtl/cb_decode.sv
// Maps the function nibble of the host address onto a function code.
// Assumes the window occupies the top quarter (nibbles 0xC..0xF).
module cb_decode
    import cb_pkg::*;
(
    input  logic [FUNC_W-1:0] func_nib,
    output func_e             func
);
    // Purely combinational nibble decode.
    always_comb begin
        unique case (func_nib)
            4'h8:                      func = FN_CTRL;
            4'hA:                      func = FN_BANK;
            4'hB:                      func = FN_PWR;
            4'hC, 4'hD, 4'hE, 4'hF:    func = FN_WIN;
            default:                   func = FN_NONE;
        endcase
    end
endmodule

// File: rtl/cb_ctrl.sv
// Holds the bridge state: on/off, bank, cartridge power and the reset-progress counter.
// Assumes one host access per cycle; the counter moves only on status reads.
module cb_ctrl
    import cb_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  func_e             func,
    input  logic [DATA_W-1:0] wdata,
    input  logic              present,
    output logic              en_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              pwr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              rst_pulse_q
);
    localparam int                BANK_MAX  = (1 << BANK_W) - 1;
    localparam logic [BANK_W-1:0] BANK_TOP  = BANK_W'(BANK_MAX);

    logic [CNT_W-1:0] cnt_step;

    // Next counter value after a status read.
    always_comb begin
        cnt_step = cnt_q;
        if (cnt_q == 2'd3 && pwr_q)       cnt_step = 2'd2;
        else if (cnt_q == 2'd2 && !pwr_q) cnt_step = 2'd1;
        else if (cnt_q == 2'd1 && !pwr_q) cnt_step = 2'd0;
    end

    // Register updates for control, bank and power writes and status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            bank_q      <= '0;
            pwr_q       <= 1'b0;
            cnt_q       <= CNT_FULL;
            rst_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= 1'b0;
            if (req && we) begin
                case (func)
                    FN_CTRL: begin
                        if (wdata == CODE_OFF) begin
                            en_q <= 1'b0;
                        end else if (wdata == CODE_ON) begin
                            if (!en_q) begin
                                bank_q <= BANK_TOP;
                                cnt_q  <= '0;
                                pwr_q  <= 1'b0;
                            end
                            en_q <= 1'b1;
                        end
                    end
                    FN_BANK: begin
                        if (en_q) begin
                            if (int'(wdata) > BANK_MAX) bank_q <= '0;
                            else                        bank_q <= wdata[BANK_W-1:0];
                        end
                    end
                    FN_PWR: begin
                        if (wdata[0]) begin
                            if (present && !pwr_q) begin
                                pwr_q       <= 1'b1;
                                cnt_q       <= CNT_FULL;
                                rst_pulse_q <= 1'b1;
                            end
                        end else begin
                            pwr_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end else if (req && func == FN_PWR) begin
                cnt_q <= cnt_step;
            end
        end
    end
endmodule

// File: rtl/cb_window.sv
// Forms the banked cartridge address and the single-cycle strobes for window accesses.
// Assumes strobes are combinational from the request so an access completes in its own cycle.
module cb_window
    import cb_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic                       req,
    input  logic                       we,
    input  func_e                      func,
    input  logic                       en,
    input  logic                       present,
    input  logic [BANK_W-1:0]          bank,
    input  logic [ADDR_W-BANK_W-1:0]   off,
    input  logic [DATA_W-1:0]          wdata,
    output logic [ADDR_W-1:0]          cart_addr,
    output logic [DATA_W-1:0]          cart_wdata,
    output logic                       cart_rd,
    output logic                       cart_wr,
    output logic                       win_ok
);
    // Window is live only when the bridge is on and a cartridge sits in the slot.
    always_comb begin
        win_ok     = (func == FN_WIN) && en && present;
        cart_addr  = {bank, off};
        cart_wdata = wdata;
        cart_rd    = req && !we && win_ok;
        cart_wr    = req &&  we && win_ok;
    end
endmodule

// File: rtl/cart_bridge.sv
// Top of the cartridge bridge: decodes host accesses, keeps bridge state and
// returns registered read data one cycle after each read request.
// Assumes a single outstanding host access per cycle.
module cart_bridge
    import cb_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [15:0]       host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              cart_present,
    input  logic [7:0]        cart_rdata,
    output logic [15:0]       cart_addr,
    output logic [7:0]        cart_wdata,
    output logic              cart_rd,
    output logic              cart_wr,
    output logic              cart_pwr,
    output logic              mapper_rst
);
    localparam int OFF_W = ADDR_W - BANK_W;

    func_e             func;
    logic              en_q;
    logic [BANK_W-1:0] bank_q;
    logic              pwr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              win_ok;
    logic [7:0]        rd_next;

    cb_decode u_dec (
        .func_nib (host_addr[ADDR_W-1 -: FUNC_W]),
        .func     (func)
    );

    cb_ctrl #(.BANK_W(BANK_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (host_req),
        .we          (host_we),
        .func        (func),
        .wdata       (host_wdata),
        .present     (cart_present),
        .en_q        (en_q),
        .bank_q      (bank_q),
        .pwr_q       (pwr_q),
        .cnt_q       (cnt_q),
        .rst_pulse_q (mapper_rst)
    );

    cb_window #(.BANK_W(BANK_W)) u_win (
        .req        (host_req),
        .we         (host_we),
        .func       (func),
        .en         (en_q),
        .present    (cart_present),
        .bank       (bank_q),
        .off        (host_addr[OFF_W-1:0]),
        .wdata      (host_wdata),
        .cart_addr  (cart_addr),
        .cart_wdata (cart_wdata),
        .cart_rd    (cart_rd),
        .cart_wr    (cart_wr),
        .win_ok     (win_ok)
    );

    assign cart_pwr = pwr_q;

    // Read-data select by function.
    always_comb begin
        unique case (func)
            FN_CTRL: rd_next = en_q ? STATUS_ON : 8'h00;
            FN_PWR:  rd_next = {en_q, 3'b000, cnt_q, 1'b0, pwr_q};
            FN_WIN:  rd_next = win_ok ? cart_rdata : 8'h00;
            default: rd_next = 8'h00;
        endcase
    end

    // Capture read data on each read request, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                     host_rdata <= 8'h00;
        else if (host_req && !host_we)  host_rdata <= rd_next;
    end
endmodule

// File: rtl/cb_checker.sv
// Temporal checks on the cartridge bridge, bound onto every instance of the top.
// Assumes visibility of the top's internal state names through the bind.
module cb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_req,
    input logic        host_we,
    input logic [15:0] host_addr,
    input logic [7:0]  host_wdata,
    input logic        cart_present,
    input logic [15:0] cart_addr,
    input logic        cart_rd,
    input logic        cart_wr,
    input logic        mapper_rst,
    input logic        en_q,
    input logic [1:0]  bank_q,
    input logic        pwr_q,
    input logic [1:0]  cnt_q
);
    // R3: enabling from off forces bank 3, counter 0, power off
    a_r3_enable_forces_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && host_addr[15:12] == 4'h8 && host_wdata == 8'h84 && !en_q)
        |=> (en_q && bank_q == 2'd3 && cnt_q == 2'd0 && !pwr_q));

    // R4: bank writes while off leave the bank alone
    a_r4_bank_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && host_addr[15:12] == 4'hA && !en_q)
        |=> $stable(bank_q));

    // R5: power-on from off gives a reset pulse and a full counter
    a_r5_power_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && host_addr[15:12] == 4'hB && host_wdata[0] && cart_present && !pwr_q)
        |=> (mapper_rst && pwr_q && cnt_q == 2'd3));

    // R5: the mapper pulse lasts a single cycle
    a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        mapper_rst |=> !mapper_rst);

    // R7: counter leaves 3 on a status read with power on
    a_r7_step_from_full: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && !host_we && host_addr[15:12] == 4'hB && cnt_q == 2'd3 && pwr_q)
        |=> cnt_q == 2'd2);

    // R7: counter never moves without a status read or a control/power write
    a_r7_counter_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req |=> $stable(cnt_q));

    // R9: strobes only with bridge on and cartridge present
    a_r9_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_rd || cart_wr) |-> (en_q && cart_present && host_addr[15:14] == 2'b11));

    // R8: strobes are mutually exclusive and carry the banked address
    a_r8_banked_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_rd || cart_wr) |-> (!(cart_rd && cart_wr) && cart_addr == {bank_q, host_addr[13:0]}));
endmodule

bind cart_bridge cb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_req     (host_req),
    .host_we      (host_we),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .cart_present (cart_present),
    .cart_addr    (cart_addr),
    .cart_rd      (cart_rd),
    .cart_wr      (cart_wr),
    .mapper_rst   (mapper_rst),
    .en_q         (en_q),
    .bank_q       (bank_q),
    .pwr_q        (pwr_q),
    .cnt_q        (cnt_q)
);

// File: tb/cart_bridge_test.sv
module cart_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        cart_present = 1'b1;
    logic [7:0]  cart_rdata = '0;
    logic [15:0] cart_addr;
    logic [7:0]  cart_wdata;
    logic        cart_rd, cart_wr, cart_pwr, mapper_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model
    bit         m_en   = 0;
    logic [1:0] m_bank = 0;
    bit         m_pwr  = 0;
    logic [1:0] m_cnt  = 3;
    logic [7:0] m_last = 0;

    always #4 clk = ~clk;

    cart_bridge uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cart_present(cart_present), .cart_rdata(cart_rdata), .cart_addr(cart_addr),
        .cart_wdata(cart_wdata), .cart_rd(cart_rd), .cart_wr(cart_wr),
        .cart_pwr(cart_pwr), .mapper_rst(mapper_rst)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] status_byte();
        return {m_en, 3'b000, m_cnt, 1'b0, m_pwr};
    endfunction

    function automatic logic [1:0] step_cnt(input logic [1:0] c, input bit p);
        if (c == 2'd3 && p)  return 2'd2;
        if (c == 2'd2 && !p) return 2'd1;
        if (c == 2'd1 && !p) return 2'd0;
        return c;
    endfunction

    // One host access with full prediction and checking.
    task automatic acc(input bit we, input logic [15:0] a, input logic [7:0] d,
                       input bit pres, input logic [7:0] crd);
        logic [3:0] fn;
        bit win, ok, pulse;
        logic [7:0] exp_rd;
        string tag;
        fn  = a[15:12];
        win = (a[15:14] == 2'b11);
        ok  = win && m_en && pres;
        host_req = 1; host_we = we; host_addr = a; host_wdata = d;
        cart_present = pres; cart_rdata = crd;
        #2;
        tag = win ? (ok ? "R8" : "R9") : "R10";
        chk(cart_rd === (!we && ok), tag, "cart_rd", cart_rd, !we && ok);
        chk(cart_wr === (we && ok),  tag, "cart_wr", cart_wr, we && ok);
        if (ok) begin
            chk(cart_addr === {m_bank, a[13:0]}, "R8", "cart_addr", cart_addr, {m_bank, a[13:0]});
            if (we) chk(cart_wdata === d, "R8", "cart_wdata", cart_wdata, d);
        end
        // prediction
        pulse = 0;
        exp_rd = 8'h00;
        case (fn)
            4'h8: exp_rd = m_en ? 8'h84 : 8'h00;
            4'hB: exp_rd = status_byte();
            4'hC, 4'hD, 4'hE, 4'hF: exp_rd = ok ? crd : 8'h00;
            default: exp_rd = 8'h00;
        endcase
        @(posedge clk); #1;
        host_req = 0;
        if (we) begin
            case (fn)
                4'h8: if (d == 8'hFE) m_en = 0;
                      else if (d == 8'h84) begin
                          if (!m_en) begin m_bank = 3; m_cnt = 0; m_pwr = 0; end
                          m_en = 1;
                      end
                4'hA: if (m_en) m_bank = (d > 3) ? 2'd0 : d[1:0];
                4'hB: if (d[0]) begin
                          if (pres && !m_pwr) begin m_pwr = 1; m_cnt = 3; pulse = 1; end
                      end else m_pwr = 0;
                default: ;
            endcase
            chk(host_rdata === m_last, "R11", "rdata hold", host_rdata, m_last);
        end else begin
            tag = (fn == 4'h8) ? "R2" : (fn == 4'hB) ? "R6" : win ? (ok ? "R8" : "R9") : "R10";
            chk(host_rdata === exp_rd, tag, "rdata", host_rdata, exp_rd);
            m_last = exp_rd;
            if (fn == 4'hB) m_cnt = step_cnt(m_cnt, m_pwr);
        end
        chk(mapper_rst === pulse, "R5", "mapper_rst", mapper_rst, pulse);
        chk(cart_pwr === m_pwr, "R5", "cart_pwr", cart_pwr, m_pwr);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250226));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk(host_rdata === 8'h00, "R1", "rdata", host_rdata, 0);
        chk(cart_pwr === 1'b0, "R1", "cart_pwr", cart_pwr, 0);
        chk(mapper_rst === 1'b0, "R1", "mapper_rst", mapper_rst, 0);
        acc(0, 16'hB000, 0, 1, 0);          // R1: status 0x0C, counter 3, power off
        acc(0, 16'h8000, 0, 1, 0);          // R2 off reads 0x00
        acc(0, 16'hC123, 0, 1, 8'h5A);      // R9 window while off
        acc(1, 16'hA000, 8'h02, 1, 0);      // R4 ignored while off
        acc(1, 16'h8000, 8'h33, 1, 0);      // R2 other byte ignored
        acc(0, 16'h8000, 0, 1, 0);
        acc(1, 16'h8000, 8'h84, 1, 0);      // R3 enable from off
        acc(0, 16'h8fff, 0, 1, 0);          // R2 on reads 0x84
        acc(0, 16'hD000, 0, 1, 8'hA5);      // R4 bank 3 seen on cart_addr
        acc(0, 16'hB000, 0, 1, 0);          // R6 0x80
        acc(1, 16'hB000, 8'h01, 1, 0);      // R5 power on, pulse
        acc(1, 16'hB000, 8'h01, 1, 0);      // R5 repeat: no pulse
        acc(0, 16'hB000, 0, 1, 0);          // R7 3->2
        acc(0, 16'hB000, 0, 1, 0);          // R7 2 holds with power on
        acc(1, 16'hB000, 8'h00, 1, 0);      // R5 power off
        acc(0, 16'hB000, 0, 1, 0);          // R7 2->1
        acc(0, 16'hB000, 0, 1, 0);          // R7 1->0
        acc(0, 16'hB000, 0, 1, 0);          // R7 stays 0
        acc(1, 16'hA000, 8'h07, 1, 0);      // R4 clamp to 0
        acc(1, 16'hE000, 8'h11, 1, 0);
        acc(1, 16'hA000, 8'h02, 1, 0);
        acc(1, 16'hFFFF, 8'h22, 1, 0);      // R8 bank 2
        acc(0, 16'hC001, 0, 0, 8'h77);      // R9 no cartridge
        acc(1, 16'hB000, 8'h01, 0, 0);      // R5 no power without cartridge
        acc(1, 16'h1234, 8'hFF, 1, 0);      // R10 undecoded write
        acc(0, 16'h9000, 0, 1, 0);          // R10 undecoded read
        acc(0, 16'hA000, 0, 1, 0);          // R10 bank not readable
        acc(1, 16'h8000, 8'h84, 1, 0);      // R3 enable while on: no change
        acc(0, 16'hC000, 0, 1, 8'h3C);
        acc(1, 16'h8000, 8'hFE, 1, 0);      // R2 off
        acc(0, 16'hC000, 0, 1, 8'h3C);      // R9
        // constrained random traffic
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [15:0] a;
            logic [7:0] d;
            bit we;
            r  = $urandom_range(0, 9);
            we = $urandom_range(0, 1);
            d  = 8'($urandom);
            case (r)
                0, 1: begin a = 16'h8000 | 16'($urandom_range(0, 4095));
                            if ($urandom_range(0, 2) == 0) d = 8'h84;
                            else if ($urandom_range(0, 1) == 0) d = 8'hFE; end
                2:    begin a = 16'hA000; d = 8'($urandom_range(0, 6)); end
                3, 4: a = 16'hB000 | 16'($urandom_range(0, 4095));
                5:    a = 16'(16'h1000 * $urandom_range(0, 7)) | 16'($urandom_range(0, 4095));
                default: a = 16'hC000 | 16'($urandom_range(0, 16383));
            endcase
            acc(we, a, d, ($urandom_range(0, 3) != 0), 8'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule